// File: doc/BRIEF.md
# RDS Receiver Host Readout Sequencer

This block sits on the host side of a radio data decoder. It reaches the decoder only through a register port with a request/acknowledge handshake. The port stands in for a serial control bus. After reset the sequencer can program the decoder's clock multiplier and then hold off every access until the multiplier has had time to lock. It then arms the decoder: a single write selects "buffer not empty" as the interrupt cause and forces a resynchronization that flushes stale data.

Once armed, the sequencer empties the decoder's block buffer in one of two ways. In interrupt mode it waits for the active-low interrupt line to fall. In polling mode it repeatedly reads the status register and tests the buffer-not-empty flag. Each block it reads leaves the sequencer as a one-cycle pulse carrying a quality word, a correction word and 16 data bits. The decoder can hand back the same block twice at the end of a drain, and such a repeat is dropped. In interrupt mode an interrupt line that stays low after a drain is flagged on a status output.

Top module: `rds_host_seq`

## Requirements
- R1: Only one bus transaction is outstanding at a time. Once `bus_req` rises, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values until a cycle in which `bus_ack` is high, and `bus_req` is low in the cycle after that.
- R2: When `skip_clk` is 0, the first transaction after reset is a write of `CLK_CFG` to address 5. No further request starts until at least `LOCK_CYC + EXTRA_CYC` cycles after that write is acknowledged.
- R3: When `skip_clk` is 1, the first transaction after reset is the arming write.
- R4: The arming write goes to address 0 with data 8'h21. Bits [2:0] = 3'b001 select "buffer not empty" as the interrupt cause, and bit 5 = 1 forces resynchronization.
- R5: In interrupt mode (`poll_mode` = 0) no read is issued while `irq_n` is high. After `irq_n` falls, the sequencer reads addresses 0, 1, 2, 3, 4 in that order.
- R6: In polling mode (`poll_mode` = 1) the sequencer reads address 0 and tests bit 6. If bit 6 is 1, it reads addresses 1, 2, 3, 4 and then reads address 0 again. If bit 6 is 0, it waits at least `POLL_GAP` cycles before the next status read.
- R7: Each block is output as a single-cycle `blk_valid` pulse with `blk_qual` = data from address 1, `blk_corr` = data from address 2 and `blk_data` = {data from address 3, data from address 4}.
- R8: A block equal in all four words to the previous block output in the same drain is not output. A polling drain ends when a status read returns bit 6 = 0. An interrupt drain ends when `irq_n` is seen high.
- R9: In interrupt mode, if `irq_n` is still low `STUCK_CYC` cycles after a block has been read, `irq_stuck` goes to 1 and the five reads are repeated. `irq_stuck` returns to 0 once `irq_n` is seen high.
- R10: During reset `bus_req`, `blk_valid` and `irq_stuck` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_mode | input | 1 | 1 selects status polling, 0 selects interrupt-driven draining |
| skip_clk | input | 1 | 1 skips the clock multiplier setup |
| irq_n | input | 1 | Decoder interrupt line, active low |
| bus_req | output | 1 | Transaction request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transaction acknowledge; read data is valid with it |
| bus_rdata | input | 8 | Read data |
| blk_valid | output | 1 | One-cycle pulse for a delivered block |
| blk_qual | output | 8 | Quality word of the block |
| blk_corr | output | 8 | Correction/flag word of the block |
| blk_data | output | 16 | Block data, high byte first |
| irq_stuck | output | 1 | Interrupt line remained low after a drain |

## Verification
The bench shrinks the waits to `LOCK_CYC` = 40, `EXTRA_CYC` = 25, `POLL_GAP` = 8 and `STUCK_CYC` = 30. With these values the lock hold-off can be measured exactly, and the spacing between empty status reads is short enough that polling drains happen several times in one run. They also make the stuck-interrupt path reachable, including its repeated re-drains, in a few hundred cycles. A behavioural decoder model acknowledges after one wait cycle and serves a queue of blocks. It lets the bench repeat a block inside one drain and across two interrupt drains, so both the drop rule and its drain boundary are exercised.

// File: rtl/rds_seq_pkg.sv
package rds_seq_pkg;
  localparam int REG_W = 8;
  localparam int REG_STAT = 0;
  localparam int REG_QUAL = 1;
  localparam int REG_CORR = 2;
  localparam int REG_DHI = 3;
  localparam int REG_DLO = 4;
  localparam int REG_CLK = 5;
  localparam int STAT_NE_BIT = 6;
  localparam logic [2:0] SRC_BNE = 3'b001;

  typedef enum logic [3:0] {
    S_BOOT, S_CLK_WR, S_LOCK, S_ARM, S_IDLE, S_IRQ_WAIT, S_READ, S_GAP, S_HOLD
  } seq_state_t;

  typedef struct packed {
    logic [REG_W-1:0] qual;
    logic [REG_W-1:0] corr;
    logic [REG_W-1:0] dhi;
    logic [REG_W-1:0] dlo;
  } rds_blk_t;

  // control word: resync at bit 5, interrupt cause in bits [2:0]
  function automatic logic [REG_W-1:0] arm_word(input logic [2:0] src);
    return {2'b00, 1'b1, 2'b00, src};
  endfunction

  function automatic logic blk_same(input rds_blk_t a, input rds_blk_t b);
    return a == b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rds_bus_port.sv
module rds_bus_port #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  input  logic          ack,
  output logic          done
);
  assign done = req & ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req   <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (done) begin
      req <= 1'b0;
    end else if (start && !req) begin
      req   <= 1'b1;
      we    <= we_i;
      addr  <= addr_i;
      wdata <= wdata_i;
    end
  end

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(addr) && $stable(we) && $stable(wdata));

  // R1
  single_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !req);
endmodule

// File: rtl/rds_wait_timer.sv
module rds_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= limit;
      run <= 1'b1;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0) && !load;
endmodule

// File: rtl/rds_dup_filter.sv
module rds_dup_filter
  import rds_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     drain_clr,
  input  logic     in_vld,
  input  rds_blk_t in_blk,
  output logic     out_vld,
  output rds_blk_t out_blk,
  output logic     dropped
);
  logic     have_prev;
  rds_blk_t prev;

  assign dropped = in_vld && have_prev && blk_same(prev, in_blk);
  assign out_blk = prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev      <= '0;
      out_vld   <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      if (drain_clr) begin
        have_prev <= 1'b0;
      end else if (in_vld && !dropped) begin
        out_vld   <= 1'b1;
        prev      <= in_blk;
        have_prev <= 1'b1;
      end
    end
  end

  // R8
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> !out_vld);

  // R7
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));
endmodule

// File: rtl/rds_host_seq.sv
module rds_host_seq
  import rds_seq_pkg::*;
#(
  parameter int         AW        = 3,
  parameter logic [7:0] CLK_CFG   = 8'h13,
  parameter int         LOCK_CYC  = 4275,
  parameter int         EXTRA_CYC = 25,
  parameter int         POLL_GAP  = 100,
  parameter int         STUCK_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll_mode,
  input  logic          skip_clk,
  input  logic          irq_n,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          blk_valid,
  output logic [7:0]    blk_qual,
  output logic [7:0]    blk_corr,
  output logic [15:0]   blk_data,
  output logic          irq_stuck
);
  localparam int LOCK_TOT = LOCK_CYC + EXTRA_CYC;
  localparam int TMAX     = max3(LOCK_TOT, POLL_GAP, STUCK_CYC);
  localparam int TW       = $clog2(TMAX + 1);

  seq_state_t    state;
  logic [2:0]    rd_idx;
  logic          pend;
  rds_blk_t      cap;
  logic          blk_rdy;
  logic          drain_clr;

  logic          bus_start;
  logic          bus_we_c;
  logic [AW-1:0] bus_addr_c;
  logic [7:0]    bus_wdata_c;
  logic          bus_done;
  logic          tmr_load;
  logic [TW-1:0] tmr_limit;
  logic          tmr_exp;
  logic          st_empty;
  logic          last_read;
  rds_blk_t      out_blk;
  logic          blk_dropped;

  // named internal events
  assign st_empty  = (state == S_READ) && bus_done && (rd_idx == 3'(REG_STAT))
                     && poll_mode && !bus_rdata[STAT_NE_BIT];
  assign last_read = (state == S_READ) && bus_done && (rd_idx == 3'(REG_DLO));

  always_comb begin
    bus_start   = !pend && ((state == S_CLK_WR) || (state == S_ARM) || (state == S_READ));
    bus_we_c    = (state != S_READ);
    bus_addr_c  = AW'(rd_idx);
    bus_wdata_c = arm_word(SRC_BNE);
    if (state == S_CLK_WR) begin
      bus_addr_c  = AW'(REG_CLK);
      bus_wdata_c = CLK_CFG;
    end else if (state == S_ARM) begin
      bus_addr_c  = AW'(REG_STAT);
    end
  end

  always_comb begin
    tmr_load  = 1'b0;
    tmr_limit = '0;
    if (state == S_CLK_WR && bus_done) begin
      tmr_load  = 1'b1;
      tmr_limit = TW'(LOCK_TOT);
    end else if (st_empty) begin
      tmr_load  = 1'b1;
      tmr_limit = TW'(POLL_GAP);
    end else if (last_read && !poll_mode) begin
      tmr_load  = 1'b1;
      tmr_limit = TW'(STUCK_CYC);
    end
  end

  rds_bus_port #(.AW(AW), .DW(8)) u_port (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .we_i(bus_we_c),
    .addr_i(bus_addr_c), .wdata_i(bus_wdata_c), .req(bus_req), .we(bus_we),
    .addr(bus_addr), .wdata(bus_wdata), .ack(bus_ack), .done(bus_done)
  );

  rds_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .limit(tmr_limit), .expired(tmr_exp)
  );

  rds_dup_filter u_filter (
    .clk(clk), .rst_n(rst_n), .drain_clr(drain_clr), .in_vld(blk_rdy),
    .in_blk(cap), .out_vld(blk_valid), .out_blk(out_blk), .dropped(blk_dropped)
  );

  assign blk_qual = out_blk.qual;
  assign blk_corr = out_blk.corr;
  assign blk_data = {out_blk.dhi, out_blk.dlo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_BOOT;
      rd_idx    <= '0;
      pend      <= 1'b0;
      cap       <= '0;
      blk_rdy   <= 1'b0;
      drain_clr <= 1'b0;
      irq_stuck <= 1'b0;
    end else begin
      blk_rdy   <= 1'b0;
      drain_clr <= 1'b0;
      if (bus_start) pend <= 1'b1;
      else if (bus_done) pend <= 1'b0;
      case (state)
        S_BOOT:   state <= skip_clk ? S_ARM : S_CLK_WR;
        S_CLK_WR: if (bus_done) state <= S_LOCK;
        S_LOCK:   if (tmr_exp) state <= S_ARM;
        S_ARM:    if (bus_done) state <= S_IDLE;
        S_IDLE: begin
          rd_idx    <= '0;
          drain_clr <= 1'b1;
          state     <= poll_mode ? S_READ : S_IRQ_WAIT;
        end
        S_IRQ_WAIT: begin
          if (irq_n) begin
            irq_stuck <= 1'b0;
          end else begin
            rd_idx    <= '0;
            drain_clr <= 1'b1;
            state     <= S_READ;
          end
        end
        S_READ: begin
          if (st_empty) begin
            drain_clr <= 1'b1;
            state     <= S_GAP;
          end else if (last_read) begin
            cap.dlo <= bus_rdata;
            blk_rdy <= 1'b1;
            rd_idx  <= '0;
            state   <= poll_mode ? S_READ : S_HOLD;
          end else if (bus_done) begin
            case (rd_idx)
              3'(REG_QUAL): cap.qual <= bus_rdata;
              3'(REG_CORR): cap.corr <= bus_rdata;
              3'(REG_DHI):  cap.dhi  <= bus_rdata;
              default: ;
            endcase
            rd_idx <= rd_idx + 3'd1;
          end
        end
        S_GAP: begin
          if (tmr_exp) begin
            rd_idx <= '0;
            state  <= S_READ;
          end
        end
        S_HOLD: begin
          if (irq_n) begin
            irq_stuck <= 1'b0;
            state     <= S_IRQ_WAIT;
          end else if (tmr_exp) begin
            irq_stuck <= 1'b1;
            rd_idx    <= '0;
            state     <= S_READ;
          end
        end
        default: state <= S_BOOT;
      endcase
    end
  end

  // R4
  arm_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && (bus_addr == AW'(REG_STAT)) |-> bus_wdata == 8'h21);

  // R9
  stuck_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stuck) |-> $past(!irq_n));

  // R7
  blk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |=> !blk_valid);

  // R2
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK) |-> !bus_req);
endmodule

// File: tb/rds_host_seq_test.sv
module rds_host_seq_test;
  localparam int         AW        = 3;
  localparam logic [7:0] CFG       = 8'h5A;
  localparam int         LOCK_CYC  = 40;
  localparam int         EXTRA_CYC = 25;
  localparam int         POLL_GAP  = 8;
  localparam int         STUCK_CYC = 30;

  // polling table: {expected output, qual, corr, data hi, data lo}
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 32'h11223344}, {1'b1, 32'h55667788}, {1'b0, 32'h55667788},
    {1'b1, 32'hA0B0C0D0}, {1'b1, 32'h0F1E2D3C}, {1'b0, 32'h0F1E2D3C}
  };

  logic clk = 0, rst_n = 0, poll_mode = 0, skip_clk = 0, irq_n = 1;
  logic bus_req, bus_we, bus_ack = 0, blk_valid, irq_stuck;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 0, blk_qual, blk_corr;
  logic [15:0] blk_data;

  always #4 clk = ~clk;

  rds_host_seq #(.AW(AW), .CLK_CFG(CFG), .LOCK_CYC(LOCK_CYC), .EXTRA_CYC(EXTRA_CYC),
                 .POLL_GAP(POLL_GAP), .STUCK_CYC(STUCK_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .poll_mode(poll_mode), .skip_clk(skip_clk), .irq_n(irq_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .blk_valid(blk_valid), .blk_qual(blk_qual),
    .blk_corr(blk_corr), .blk_data(blk_data), .irq_stuck(irq_stuck)
  );

  int checks = 0, errors = 0;
  int cyc = 0, lat = 0, n_blk = 0, rd_ptr = 0, tr_n = 0, em_cnt = 0, clk_ack_cyc = 0;
  logic irq_en = 0, force_low = 0, prev_req = 0;
  logic [31:0] blk_mem [16];
  logic [2:0]  tr_addr [1024];
  logic        tr_we [1024];
  logic [7:0]  tr_wd [1024];
  int          tr_cyc [1024];
  logic [31:0] em_arr [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // decoder model and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      bus_ack = 0; lat = 0; prev_req = 0;
    end else begin
      if (bus_req && !prev_req && tr_n < 1024) begin
        tr_addr[tr_n] = bus_addr; tr_we[tr_n] = bus_we;
        tr_wd[tr_n] = bus_wdata; tr_cyc[tr_n] = cyc; tr_n++;
      end
      prev_req = bus_req;
      if (bus_ack) bus_ack = 0;
      else if (bus_req) begin
        if (lat == 1) begin
          lat = 0; bus_ack = 1;
          if (bus_we) begin
            if (bus_addr == 3'd5) clk_ack_cyc = cyc;
            if (bus_addr == 3'd0 && bus_wdata[5]) rd_ptr = n_blk;
          end else if (bus_addr == 3'd0) begin
            bus_rdata = {1'b0, rd_ptr < n_blk, 6'b0};
          end else if (rd_ptr < n_blk) begin
            case (bus_addr)
              3'd1: bus_rdata = blk_mem[rd_ptr][31:24];
              3'd2: bus_rdata = blk_mem[rd_ptr][23:16];
              3'd3: bus_rdata = blk_mem[rd_ptr][15:8];
              default: begin bus_rdata = blk_mem[rd_ptr][7:0]; rd_ptr++; end
            endcase
          end else bus_rdata = 8'h00;
        end else lat++;
      end
      if (blk_valid && em_cnt < 64) begin
        em_arr[em_cnt] = {blk_qual, blk_corr, blk_data};
        em_cnt++;
      end
    end
    irq_n = ~(((rd_ptr < n_blk) && irq_en) || force_low);
  end

  task automatic do_reset(input logic skip, input logic poll);
    @(posedge clk); #1;
    rst_n = 0; skip_clk = skip; poll_mode = poll; irq_en = !poll; force_low = 0;
    n_blk = 0; rd_ptr = 0; tr_n = 0; em_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    chk(bus_req == 0, "R10", "bus_req in reset", bus_req, 0);
    chk(blk_valid == 0, "R10", "blk_valid in reset", blk_valid, 0);
    chk(irq_stuck == 0, "R10", "irq_stuck in reset", irq_stuck, 0);
    rst_n = 1;
  endtask

  task automatic load_blk(input logic [31:0] w);
    blk_mem[n_blk] = w; n_blk++;
  endtask

  function automatic int find_qual_read(input int from);
    for (int i = from; i < tr_n; i++) if (!tr_we[i] && tr_addr[i] == 3'd1) return i;
    return -1;
  endfunction

  task automatic chk_read_order(input int mark, input string req);
    int k;
    k = find_qual_read(mark);
    chk(k > 0, req, "quality read found", k, 1);
    if (k > 0) begin
      chk(tr_addr[k-1] == 0 && !tr_we[k-1], req, "status read before block", tr_addr[k-1], 0);
      chk(tr_addr[k+1] == 2 && tr_addr[k+2] == 3 && tr_addr[k+3] == 4, req, "read order 2,3,4",
          {tr_addr[k+1], tr_addr[k+2], tr_addr[k+3]}, {3'd2, 3'd3, 3'd4});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int mark, exp_n;
    logic [31:0] exp_arr [6];

    // clock setup then polling
    do_reset(1'b0, 1'b1);
    for (int t = 0; t < 500 && tr_n < 2; t++) @(negedge clk);
    // R2
    chk(tr_we[0] && tr_addr[0] == 3'd5 && tr_wd[0] == CFG, "R2", "clock write",
        {tr_we[0], tr_addr[0], tr_wd[0]}, {1'b1, 3'd5, CFG});
    chk(tr_cyc[1] - clk_ack_cyc >= LOCK_CYC + EXTRA_CYC, "R2", "lock hold-off",
        tr_cyc[1] - clk_ack_cyc, LOCK_CYC + EXTRA_CYC);
    // R4
    chk(tr_we[1] && tr_addr[1] == 3'd0 && tr_wd[1] == 8'h21, "R4", "arming write",
        {tr_we[1], tr_addr[1], tr_wd[1]}, {1'b1, 3'd0, 8'h21});
    repeat (50) @(posedge clk);
    #1;
    mark = tr_n; exp_n = 0;
    for (int i = 0; i < 6; i++) begin
      load_blk(VEC[i][31:0]);
      if (VEC[i][32]) begin exp_arr[exp_n] = VEC[i][31:0]; exp_n++; end
    end
    for (int t = 0; t < 2000 && rd_ptr < n_blk; t++) @(negedge clk);
    repeat (60) @(negedge clk);
    // R8: repeats inside one drain removed
    chk(em_cnt == exp_n, "R8", "polled block count", em_cnt, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(em_arr[i] == exp_arr[i], "R7", "polled block contents", em_arr[i], exp_arr[i]);
    // R6
    chk_read_order(mark, "R6");
    chk(!tr_we[tr_n-1] && tr_addr[tr_n-1] == 0 && tr_addr[tr_n-2] == 0 &&
        tr_cyc[tr_n-1] - tr_cyc[tr_n-2] >= POLL_GAP, "R6", "empty status spacing",
        tr_cyc[tr_n-1] - tr_cyc[tr_n-2], POLL_GAP);

    // interrupt mode, clock setup skipped
    do_reset(1'b1, 1'b0);
    repeat (100) @(negedge clk);
    // R3
    chk(tr_n >= 1 && tr_we[0] && tr_addr[0] == 0 && tr_wd[0] == 8'h21, "R3", "first access is arm",
        {tr_we[0], tr_addr[0], tr_wd[0]}, {1'b1, 3'd0, 8'h21});
    // R5
    chk(tr_n == 1, "R5", "no reads while irq_n high", tr_n, 1);
    @(posedge clk); #1;
    mark = tr_n;
    load_blk(32'hCAFE1234);
    repeat (60) @(negedge clk);
    chk_read_order(mark, "R5");
    // R7
    chk(em_cnt == 1 && em_arr[0] == 32'hCAFE1234, "R7", "interrupt block", em_arr[0], 32'hCAFE1234);
    @(posedge clk); #1;
    load_blk(32'hCAFE1234);
    repeat (60) @(negedge clk);
    // R8: equal block in a new drain still delivered
    chk(em_cnt == 2, "R8", "repeat across drains", em_cnt, 2);
    chk(irq_stuck == 0, "R9", "no stuck after clean drain", irq_stuck, 0);

    @(posedge clk); #1;
    force_low = 1;
    load_blk(32'h01020304);
    for (int t = 0; t < STUCK_CYC + 200 && !irq_stuck; t++) @(negedge clk);
    // R9
    chk(irq_stuck == 1, "R9", "stuck flag raised", irq_stuck, 1);
    repeat (3 * STUCK_CYC + 60) @(negedge clk);
    chk(em_cnt == 4 && em_arr[2] == 32'h01020304 && em_arr[3] == 32'h0, "R8",
        "re-drain repeats dropped", em_cnt, 4);
    @(posedge clk); #1;
    force_low = 0;
    repeat (60) @(negedge clk);
    chk(irq_stuck == 0, "R9", "stuck flag cleared", irq_stuck, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule